// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block decides when the processor core and its peripherals receive clock. Software writes a small control register whose low two bits request a low-power state. A request for idle stops only the CPU clock, which freezes instruction execution while timers, serial ports and interrupt logic keep running. A request for power-down stops the peripheral clock as well. The block drives two clock-enable signals that a clock-gating cell outside the block uses.

The mode is entered on the clock edge that accepts the register write, so no instruction after the writing one executes. A pending enabled interrupt brings the core back from idle and clears the idle request bit in hardware. Power-down is left only through reset or through a pending enabled external interrupt, which clears both request bits. The core is therefore never left in idle after power-down ends, even when software set both bits in one write. Wake-up never resets anything, so the state of the CPU, the register and the RAM carries across any sleep.

Top module: `pmode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `cpu_clk_en`=1, `per_clk_en`=1 and `mode_status`=0, and `reg_rd_data` reads all zeros.
- R2: A register write accepted in the running state with bit 0 (idle request) = 1 and bit 1 (power-down request) = 0 gives, from the next cycle on, `mode_status`=1 (idle), `cpu_clk_en`=0 and `per_clk_en`=1.
- R3: A register write accepted in the running state with bit 1 = 1 gives, from the next cycle on, `mode_status`=2 (power-down) with both clock enables at 0. This holds whatever the value of bit 0.
- R4: In idle, a high `irq_pending` or `ext_irq_pending` at a clock edge returns the block to `mode_status`=0 with `cpu_clk_en`=1 after that edge. Bit 0 of the readback is then 0, and every other register bit keeps its value.
- R5: In power-down, `irq_pending` alone does not wake the block, and the mode stays 2. A high `ext_irq_pending` returns it to `mode_status`=0 with both clocks enabled. Bits 0 and 1 of the readback are then both 0, so idle is not entered afterwards.
- R6: Register writes made while the mode is not running are ignored, and the readback keeps its value.
- R7: A write accepted in the running state with bits 0 and 1 both 0 stores the full written value, which reads back exactly on the next cycle. The mode stays 0 and both clocks stay enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the control register |
| reg_wr_data | input | REG_W | Write data; bit 0 requests idle, bit 1 requests power-down |
| irq_pending | input | 1 | Some enabled interrupt is pending |
| ext_irq_pending | input | 1 | An enabled external interrupt is pending |
| cpu_clk_en | output | 1 | Registered CPU clock enable |
| per_clk_en | output | 1 | Registered peripheral clock enable |
| mode_status | output | 2 | 0 running, 1 idle, 2 power-down |
| reg_rd_data | output | REG_W | Control register readback |

## Verification
Any fault in the mode state shows up at the ports one cycle after the edge that caused it. The fault appears as a mode code or clock enable that does not match the last accepted write or wake event, or as a request bit in the readback that was not cleared on wake. A wake path that clears the idle bit but not the power-down bit leaves bit 1 set in the readback right after a power-down wake. A write that is not masked during sleep changes the readback one cycle after the write strobe. Sweeping every write value from the running state covers every combination of request bits and payload bits.

// File: rtl/pmode_pkg.sv
package pmode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } pmode_e;
endpackage

// File: rtl/pmode_reg.sv
module pmode_reg #(
  parameter int REG_W    = 8,
  parameter int IDLE_BIT = 0,
  parameter int PD_BIT   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_take,
  input  logic [REG_W-1:0] wr_data,
  input  logic             clr_idle,
  input  logic             clr_pd,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] clr_mask;

  for (genvar i = 0; i < REG_W; i++) begin : g_mask
    if (i == IDLE_BIT) begin : g_idle
      assign clr_mask[i] = clr_idle;
    end else if (i == PD_BIT) begin : g_pd
      assign clr_mask[i] = clr_pd;
    end else begin : g_keep
      assign clr_mask[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr_take) begin
      q <= wr_data;
    end else begin
      q <= q & ~clr_mask;
    end
  end
endmodule

// File: rtl/pmode_seq.sv
module pmode_seq
  import pmode_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wr_en,
  input  logic   req_idle,
  input  logic   req_pd,
  input  logic   irq_pending,
  input  logic   ext_irq_pending,
  output logic   wr_take,
  output logic   clr_idle,
  output logic   clr_pd,
  output pmode_e mode_nxt
);
  pmode_e mode_q;
  logic   wake_idle;
  logic   wake_pd;

  assign wr_take   = wr_en && (mode_q == MODE_RUN);
  assign wake_idle = (mode_q == MODE_IDLE) && (irq_pending || ext_irq_pending);
  assign wake_pd   = (mode_q == MODE_PDOWN) && ext_irq_pending;
  assign clr_idle  = wake_idle || wake_pd;
  assign clr_pd    = wake_pd;

  always_comb begin
    mode_nxt = mode_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (wr_take && req_pd)        mode_nxt = MODE_PDOWN;
        else if (wr_take && req_idle) mode_nxt = MODE_IDLE;
      end
      MODE_IDLE:  if (wake_idle) mode_nxt = MODE_RUN;
      MODE_PDOWN: if (wake_pd)   mode_nxt = MODE_RUN;
      default:    mode_nxt = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_RUN;
    else     mode_q <= mode_nxt;
  end
endmodule

// File: rtl/pmode_clken.sv
module pmode_clken
  import pmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pmode_e     mode_nxt,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic [1:0] mode_status
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en  <= 1'b1;
      per_clk_en  <= 1'b1;
      mode_status <= MODE_RUN;
    end else begin
      cpu_clk_en  <= (mode_nxt == MODE_RUN);
      per_clk_en  <= (mode_nxt != MODE_PDOWN);
      mode_status <= mode_nxt;
    end
  end
endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
  import pmode_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int IDLE_BIT = 0,
  parameter int PD_BIT   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  input  logic             irq_pending,
  input  logic             ext_irq_pending,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic [1:0]       mode_status,
  output logic [REG_W-1:0] reg_rd_data
);
  logic   wr_take;
  logic   clr_idle;
  logic   clr_pd;
  pmode_e mode_nxt;

  pmode_seq u_seq (
    .clk             (clk),
    .rst             (rst),
    .wr_en           (reg_wr_en),
    .req_idle        (reg_wr_data[IDLE_BIT]),
    .req_pd          (reg_wr_data[PD_BIT]),
    .irq_pending     (irq_pending),
    .ext_irq_pending (ext_irq_pending),
    .wr_take         (wr_take),
    .clr_idle        (clr_idle),
    .clr_pd          (clr_pd),
    .mode_nxt        (mode_nxt)
  );

  pmode_reg #(
    .REG_W    (REG_W),
    .IDLE_BIT (IDLE_BIT),
    .PD_BIT   (PD_BIT)
  ) u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_take  (wr_take),
    .wr_data  (reg_wr_data),
    .clr_idle (clr_idle),
    .clr_pd   (clr_pd),
    .q        (reg_rd_data)
  );

  pmode_clken u_clken (
    .clk         (clk),
    .rst         (rst),
    .mode_nxt    (mode_nxt),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .mode_status (mode_status)
  );
endmodule

// File: rtl/pmode_ctrl_chk.sv
module pmode_ctrl_chk #(
  parameter int REG_W    = 8,
  parameter int IDLE_BIT = 0,
  parameter int PD_BIT   = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr_en,
  input logic [REG_W-1:0] reg_wr_data,
  input logic             irq_pending,
  input logic             ext_irq_pending,
  input logic             cpu_clk_en,
  input logic             per_clk_en,
  input logic [1:0]       mode_status,
  input logic [REG_W-1:0] reg_rd_data
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (mode_status == 2'd0) && cpu_clk_en && per_clk_en && (reg_rd_data == '0));

  assert_idle_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 2'd0) && reg_wr_en && reg_wr_data[IDLE_BIT] && !reg_wr_data[PD_BIT]
    |=> (mode_status == 2'd1) && !cpu_clk_en && per_clk_en);

  assert_pdown_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 2'd0) && reg_wr_en && reg_wr_data[PD_BIT]
    |=> (mode_status == 2'd2) && !cpu_clk_en && !per_clk_en);

  assert_idle_wake_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 2'd1) && (irq_pending || ext_irq_pending)
    |=> (mode_status == 2'd0) && cpu_clk_en && !reg_rd_data[IDLE_BIT]);

  assert_pdown_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 2'd2) && !ext_irq_pending |=> (mode_status == 2'd2));

  assert_pdown_wake_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 2'd2) && ext_irq_pending
    |=> (mode_status == 2'd0) && cpu_clk_en && per_clk_en
        && !reg_rd_data[IDLE_BIT] && !reg_rd_data[PD_BIT]);

  assert_sleep_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_status != 2'd0) && reg_wr_en && !irq_pending && !ext_irq_pending
    |=> $stable(reg_rd_data));

  assert_plain_write_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 2'd0) && reg_wr_en && !reg_wr_data[IDLE_BIT] && !reg_wr_data[PD_BIT]
    |=> (reg_rd_data == $past(reg_wr_data)) && (mode_status == 2'd0) && cpu_clk_en && per_clk_en);
endmodule

bind pmode_ctrl pmode_ctrl_chk #(
  .REG_W    (REG_W),
  .IDLE_BIT (IDLE_BIT),
  .PD_BIT   (PD_BIT)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .reg_wr_en       (reg_wr_en),
  .reg_wr_data     (reg_wr_data),
  .irq_pending     (irq_pending),
  .ext_irq_pending (ext_irq_pending),
  .cpu_clk_en      (cpu_clk_en),
  .per_clk_en      (per_clk_en),
  .mode_status     (mode_status),
  .reg_rd_data     (reg_rd_data)
);

// File: tb/pmode_ctrl_bench.sv
module pmode_ctrl_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wr_en = 1'b0;
  logic [W-1:0] reg_wr_data = '0;
  logic         irq_pending = 1'b0;
  logic         ext_irq_pending = 1'b0;
  logic         cpu_clk_en;
  logic         per_clk_en;
  logic [1:0]   mode_status;
  logic [W-1:0] reg_rd_data;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pmode_ctrl #(.REG_W(W), .IDLE_BIT(0), .PD_BIT(1)) u_pmode_ctrl (
    .clk             (clk),
    .rst             (rst),
    .reg_wr_en       (reg_wr_en),
    .reg_wr_data     (reg_wr_data),
    .irq_pending     (irq_pending),
    .ext_irq_pending (ext_irq_pending),
    .cpu_clk_en      (cpu_clk_en),
    .per_clk_en      (per_clk_en),
    .mode_status     (mode_status),
    .reg_rd_data     (reg_rd_data)
  );

  task automatic check(string req, logic [W+3:0] act, logic [W+3:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // packs {mode, cpu_en, per_en, readback}
  function automatic logic [W+3:0] pack(logic [1:0] m, logic c, logic p, logic [W-1:0] r);
    return {m, c, p, r};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int v = 0; v < (1 << W); v++) begin
      logic [W-1:0] val;
      val = W'(v);
      rst = 1'b1;
      tick();
      tick();
      check("R1", pack(mode_status, cpu_clk_en, per_clk_en, reg_rd_data), pack(2'd0, 1'b1, 1'b1, '0));
      rst = 1'b0;
      reg_wr_en = 1'b1;
      reg_wr_data = val;
      tick();
      reg_wr_en = 1'b0;
      if (val[1]) begin
        check("R3", pack(mode_status, cpu_clk_en, per_clk_en, reg_rd_data), pack(2'd2, 1'b0, 1'b0, val));
      end else if (val[0]) begin
        check("R2", pack(mode_status, cpu_clk_en, per_clk_en, reg_rd_data), pack(2'd1, 1'b0, 1'b1, val));
      end else begin
        check("R7", pack(mode_status, cpu_clk_en, per_clk_en, reg_rd_data), pack(2'd0, 1'b1, 1'b1, val));
      end
      if (val[1] || val[0]) begin
        reg_wr_en = 1'b1;
        reg_wr_data = ~val;
        tick();
        reg_wr_en = 1'b0;
        check("R6", {2'b00, 2'b00, reg_rd_data}, {2'b00, 2'b00, val});
      end
      if (val[1]) begin
        irq_pending = 1'b1;
        tick();
        irq_pending = 1'b0;
        check("R5", pack(mode_status, cpu_clk_en, per_clk_en, reg_rd_data), pack(2'd2, 1'b0, 1'b0, val));
        ext_irq_pending = 1'b1;
        tick();
        ext_irq_pending = 1'b0;
        check("R5", pack(mode_status, cpu_clk_en, per_clk_en, reg_rd_data), pack(2'd0, 1'b1, 1'b1, val & ~W'(3)));
        tick();
        check("R5", {2'b00, mode_status, reg_rd_data}, {2'b00, 2'd0, val & ~W'(3)});
      end else if (val[0]) begin
        if (v[2]) ext_irq_pending = 1'b1;
        else      irq_pending = 1'b1;
        tick();
        irq_pending = 1'b0;
        ext_irq_pending = 1'b0;
        check("R4", pack(mode_status, cpu_clk_en, per_clk_en, reg_rd_data), pack(2'd0, 1'b1, 1'b1, val & ~W'(1)));
      end
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule